// File: doc/BRIEF.md
# Shared Wired-OR Error Line Agent

This block is one agent's share of a shared, active-low, wired-OR error line that every agent on a bus can pull. The driver half turns qualified error requests into a fixed-length pull on the line. It starts a pull only after it has seen the line released. If it finds that a competitor began pulling one clock before its own start, it cuts the pull short so that both release together. The receiver half watches the line and turns the start of each active episode into a single-cycle local event.

One elaboration parameter selects the line's role. In the fault role, an observed episode becomes a machine-check request, and only when machine-check is enabled. In the initialization role, an observed episode becomes a bus-reset pulse. The surrounding logic uses that pulse to clear its bus state machines, its rotating arbitration ID and its internal counts. Power-on configuration bits are captured once, on the first clock after reset is released, and held from then on.

The inputs `line_seen` and `others_seen` are pad samples taken one clock late. They are active high: 1 means the line, or some other agent's drive, is pulled. The output `drive_en` is the open-drain pull enable.

Top module: `err_line_agent`

## Requirements
- R1: A qualified request accepted on a clock where `line_seen` is 0 produces `drive_en` high for exactly PULSE_CLKS (3) consecutive clocks, starting the clock after acceptance.
- R2: No pull starts on a clock where `line_seen` is 1. A request present on such a clock is discarded and never produces a pull later.
- R3: If, on the first clock of its own pull, the agent sees `others_seen` go from 0 to 1, its pull lasts EARLY_CLKS (2) clocks. It ends on the same clock as the pull of the agent that started one clock earlier.
- R4: Agents that start on the same clock each pull for the full 3 clocks and release together.
- R5: With the driver-enable configuration bit at 0, no request of any kind raises `drive_en`.
- R6: A request qualifies in three cases: `int_err` with the internal-source enable; `txn_err` with the any-observed-error enable; or `txn_err` with the initiator-only enable while `txn_mine` is 1. A `txn_err` with `txn_mine` at 0 under initiator-only does not qualify, and neither does `int_err` without its enable.
- R7: With the receiver-enable configuration bit at 0, an active line raises neither `mce_req` nor `bus_reset`.
- R8: In the fault role (LINE_ROLE=0), each episode of `line_seen` (a 0 to 1 transition) gives exactly one single-cycle `mce_req` pulse when both receiver and machine-check are enabled, and none when machine-check is disabled. `bus_reset` stays 0.
- R9: In the initialization role (LINE_ROLE=1), each episode gives exactly one single-cycle `bus_reset` pulse when the receiver is enabled. `mce_req` stays 0.
- R10: The configuration inputs are captured on the first clock after `rst_n` rises. Later changes to them have no effect until the next reset.
- R11: While `rst_n` is 0, `drive_en`, `mce_req` and `bus_reset` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_drv_en | input | 1 | Driver enable (captured once) |
| cfg_int_src | input | 1 | Pull on internal errors |
| cfg_init_src | input | 1 | Pull on transaction errors only when this agent initiated |
| cfg_any_src | input | 1 | Pull on any observed transaction error |
| cfg_rcv_en | input | 1 | Receiver enable |
| cfg_mce_en | input | 1 | Machine-check enable (fault role) |
| int_err | input | 1 | Internal error detected (with the internal-error indication) |
| txn_err | input | 1 | Error observed in a bus transaction |
| txn_mine | input | 1 | This agent initiated the failing transaction |
| line_seen | input | 1 | Sampled shared line, 1 = pulled |
| others_seen | input | 1 | Sampled OR of the other agents' pulls, 1 = pulled |
| drive_en | output | 1 | Open-drain pull enable |
| mce_req | output | 1 | Single-cycle machine-check entry request |
| bus_reset | output | 1 | Single-cycle bus-reset pulse |

## Verification
The checker assumes that `line_seen` and `others_seen` come from registered samples of a wired-OR that includes this agent's own pull. It also assumes that configuration inputs are only meaningful around reset. The bench respects both. It models the line as a one-clock-late OR of all agents' `drive_en` outputs and a per-agent OR of the other agents' pulls. It changes configuration only while reset is held, except in the test that shows late changes are ignored. It launches requests on falling edges and only from quiet lines, apart from the deliberate collision cases. The width checks by counter also assume that requests never overlap an agent's own pull.

// File: rtl/err_line_pkg.sv
package err_line_pkg;

  localparam int ROLE_FAULT = 0;
  localparam int ROLE_INIT  = 1;

  typedef struct packed {
    logic drv_en;
    logic int_src;
    logic init_src;
    logic any_src;
    logic rcv_en;
    logic mce_en;
  } agent_cfg_t;

  typedef enum logic {DRV_IDLE = 1'b0, DRV_ON = 1'b1} drv_state_e;

  // request qualification against the captured configuration
  function automatic logic err_qualifies(agent_cfg_t c, logic ie, logic te, logic mine);
    return c.drv_en & ((ie & c.int_src) | (te & (c.any_src | (c.init_src & mine))));
  endfunction

  // first clock of an active sample
  function automatic logic first_edge(logic now_v, logic prev_v);
    return now_v & ~prev_v;
  endfunction

  // receiver arming for a given role
  function automatic logic rcv_armed(int role, logic rcv, logic mce);
    return rcv & ((role == ROLE_INIT) | mce);
  endfunction

endpackage

// File: rtl/err_cfg_latch.sv
module err_cfg_latch
  import err_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  agent_cfg_t cfg_in,
  output agent_cfg_t cfg_q,
  output logic       cfg_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cfg_done <= 1'b0;
    end else if (!cfg_done) begin
      cfg_q    <= cfg_in;
      cfg_done <= 1'b1;
    end
  end

endmodule

// File: rtl/err_req_pend.sv
module err_req_pend
  import err_line_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  agent_cfg_t cfg_q,
  input  logic       cfg_done,
  input  logic       int_err,
  input  logic       txn_err,
  input  logic       txn_mine,
  input  logic       line_seen,
  input  logic       accept,
  output logic       want
);

  logic hit;
  logic pend_q;

  assign hit  = cfg_done & err_qualifies(cfg_q, int_err, txn_err, txn_mine);
  assign want = hit | pend_q;

  // one pending slot: held until accepted, dropped on an active line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= want & ~line_seen & ~accept;
  end

endmodule

// File: rtl/err_drv_seq.sv
module err_drv_seq
  import err_line_pkg::*;
#(
  parameter int PULSE_CLKS = 3,
  parameter int EARLY_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic line_seen,
  input  logic others_seen,
  output logic accept,
  output logic early_cut,
  output logic drive_en
);

  localparam int CW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
  localparam logic [CW-1:0] LAST_FULL  = CW'(PULSE_CLKS - 1);
  localparam logic [CW-1:0] LAST_EARLY = CW'(EARLY_CLKS - 1);

  drv_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          cut_q;
  logic          others_q;
  logic          others_rise;
  logic          last;

  assign others_rise = first_edge(others_seen, others_q);
  assign accept      = (state_q == DRV_IDLE) & want & ~line_seen;
  assign early_cut   = (state_q == DRV_ON) & (cnt_q == '0) & others_rise;
  assign last        = (cnt_q == LAST_FULL) | ((cut_q | early_cut) & (cnt_q == LAST_EARLY));
  assign drive_en    = (state_q == DRV_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= DRV_IDLE;
      cnt_q    <= '0;
      cut_q    <= 1'b0;
      others_q <= 1'b0;
    end else begin
      others_q <= others_seen;
      case (state_q)
        DRV_IDLE: begin
          if (accept) begin
            state_q <= DRV_ON;
            cnt_q   <= '0;
            cut_q   <= 1'b0;
          end
        end
        default: begin
          if (last) begin
            state_q <= DRV_IDLE;
            cut_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            cut_q <= cut_q | early_cut;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/err_rcv.sv
module err_rcv
  import err_line_pkg::*;
#(
  parameter int LINE_ROLE = ROLE_FAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_seen,
  input  logic rcv_en,
  input  logic mce_en,
  output logic line_rise,
  output logic mce_req,
  output logic bus_reset
);

  logic line_q;
  logic event_q;

  assign line_rise = first_edge(line_seen, line_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      event_q <= 1'b0;
    end else begin
      line_q  <= line_seen;
      event_q <= line_rise & rcv_armed(LINE_ROLE, rcv_en, mce_en);
    end
  end

  generate
    if (LINE_ROLE == ROLE_INIT) begin : g_init
      assign bus_reset = event_q;
      assign mce_req   = 1'b0;
    end else begin : g_fault
      assign mce_req   = event_q;
      assign bus_reset = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/err_line_agent.sv
module err_line_agent
  import err_line_pkg::*;
#(
  parameter int LINE_ROLE  = ROLE_FAULT,
  parameter int PULSE_CLKS = 3,
  parameter int EARLY_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_drv_en,
  input  logic cfg_int_src,
  input  logic cfg_init_src,
  input  logic cfg_any_src,
  input  logic cfg_rcv_en,
  input  logic cfg_mce_en,
  input  logic int_err,
  input  logic txn_err,
  input  logic txn_mine,
  input  logic line_seen,
  input  logic others_seen,
  output logic drive_en,
  output logic mce_req,
  output logic bus_reset
);

  agent_cfg_t cfg_in;
  agent_cfg_t cfg_q;
  logic       cfg_done;
  logic       want;
  logic       accept;
  logic       early_cut;
  logic       line_rise;

  assign cfg_in = '{drv_en: cfg_drv_en, int_src: cfg_int_src, init_src: cfg_init_src,
                    any_src: cfg_any_src, rcv_en: cfg_rcv_en, mce_en: cfg_mce_en};

  err_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .cfg_q(cfg_q), .cfg_done(cfg_done)
  );

  err_req_pend u_pend (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .cfg_done(cfg_done),
    .int_err(int_err), .txn_err(txn_err), .txn_mine(txn_mine),
    .line_seen(line_seen), .accept(accept), .want(want)
  );

  err_drv_seq #(.PULSE_CLKS(PULSE_CLKS), .EARLY_CLKS(EARLY_CLKS)) u_drv (
    .clk(clk), .rst_n(rst_n), .want(want), .line_seen(line_seen),
    .others_seen(others_seen), .accept(accept), .early_cut(early_cut), .drive_en(drive_en)
  );

  err_rcv #(.LINE_ROLE(LINE_ROLE)) u_rcv (
    .clk(clk), .rst_n(rst_n), .line_seen(line_seen), .rcv_en(cfg_q.rcv_en),
    .mce_en(cfg_q.mce_en), .line_rise(line_rise), .mce_req(mce_req), .bus_reset(bus_reset)
  );

endmodule

// File: rtl/err_line_agent_chk.sv
module err_line_agent_chk #(
  parameter int PULSE_CLKS = 3,
  parameter int EARLY_CLKS = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_done,
  input logic cfg_drv,
  input logic cfg_rcv,
  input logic cfg_mce,
  input logic line_seen,
  input logic line_rise,
  input logic drive_en,
  input logic early_cut,
  input logic mce_req,
  input logic bus_reset
);

  logic [15:0] run_q;
  logic        cut_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      cut_seen_q <= 1'b0;
    end else begin
      run_q      <= drive_en ? ((run_q == 16'hFFFF) ? run_q : run_q + 16'd1) : 16'd0;
      cut_seen_q <= drive_en & (cut_seen_q | early_cut);
    end
  end

  // R1
  pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> run_q < 16'(PULSE_CLKS));

  // R1
  pulse_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q != 16'd0 && run_q < 16'(EARLY_CLKS)) |-> drive_en);

  // R2
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> !$past(line_seen));

  // R3
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && (cut_seen_q || early_cut)) |-> run_q < 16'(EARLY_CLKS));

  // R5
  drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !cfg_drv) |-> !drive_en);

  // R7
  rcv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mce_req || bus_reset) |-> cfg_rcv);

  // R8
  mce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mce_req |-> (cfg_mce && $past(line_rise)));

  // R8
  mce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mce_req |=> !mce_req);

  // R9
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_done) |-> ($stable(cfg_drv) && $stable(cfg_rcv) && $stable(cfg_mce)));

endmodule

bind err_line_agent err_line_agent_chk #(.PULSE_CLKS(PULSE_CLKS), .EARLY_CLKS(EARLY_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cfg_drv(cfg_q.drv_en),
  .cfg_rcv(cfg_q.rcv_en), .cfg_mce(cfg_q.mce_en), .line_seen(line_seen),
  .line_rise(line_rise), .drive_en(drive_en), .early_cut(early_cut),
  .mce_req(mce_req), .bus_reset(bus_reset)
);

// File: tb/err_line_agent_tb.sv
module err_line_agent_tb;
  import err_line_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  // cfg bit order: [5]drv [4]int [3]init [2]any [1]rcv [0]mce
  logic [5:0] cfg_a [4];
  logic [3:0] int_err = '0;
  logic [3:0] txn_err = '0;
  logic [3:0] txn_mine = '0;
  logic [3:0] drv;
  logic [3:0] mce;
  logic [3:0] brst;
  logic       line_seen = 1'b0;
  logic [3:0] oth_seen = '0;

  int tests = 0, fails = 0, cyc = 0;
  int run0 = 0, run1 = 0, pulses0 = 0, last_w1 = 0, fall0 = 0, fall1 = 0;
  int mce0_cnt = 0, brst0_cnt = 0, brst3_cnt = 0;
  int exp_q[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-OR line model with one-clock pad sampling
  always @(posedge clk) begin
    cyc <= cyc + 1;
    line_seen <= rst_n ? |drv : 1'b0;
    for (int k = 0; k < 4; k++) oth_seen[k] <= rst_n ? |(drv & ~(4'b1 << k)) : 1'b0;
  end

  err_line_agent #(.LINE_ROLE(ROLE_FAULT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_drv_en(cfg_a[0][5]), .cfg_int_src(cfg_a[0][4]),
    .cfg_init_src(cfg_a[0][3]), .cfg_any_src(cfg_a[0][2]), .cfg_rcv_en(cfg_a[0][1]),
    .cfg_mce_en(cfg_a[0][0]), .int_err(int_err[0]), .txn_err(txn_err[0]),
    .txn_mine(txn_mine[0]), .line_seen(line_seen), .others_seen(oth_seen[0]),
    .drive_en(drv[0]), .mce_req(mce[0]), .bus_reset(brst[0]));

  err_line_agent #(.LINE_ROLE(ROLE_FAULT)) u_a1 (
    .clk(clk), .rst_n(rst_n), .cfg_drv_en(cfg_a[1][5]), .cfg_int_src(cfg_a[1][4]),
    .cfg_init_src(cfg_a[1][3]), .cfg_any_src(cfg_a[1][2]), .cfg_rcv_en(cfg_a[1][1]),
    .cfg_mce_en(cfg_a[1][0]), .int_err(int_err[1]), .txn_err(txn_err[1]),
    .txn_mine(txn_mine[1]), .line_seen(line_seen), .others_seen(oth_seen[1]),
    .drive_en(drv[1]), .mce_req(mce[1]), .bus_reset(brst[1]));

  err_line_agent #(.LINE_ROLE(ROLE_FAULT)) u_a2 (
    .clk(clk), .rst_n(rst_n), .cfg_drv_en(cfg_a[2][5]), .cfg_int_src(cfg_a[2][4]),
    .cfg_init_src(cfg_a[2][3]), .cfg_any_src(cfg_a[2][2]), .cfg_rcv_en(cfg_a[2][1]),
    .cfg_mce_en(cfg_a[2][0]), .int_err(int_err[2]), .txn_err(txn_err[2]),
    .txn_mine(txn_mine[2]), .line_seen(line_seen), .others_seen(oth_seen[2]),
    .drive_en(drv[2]), .mce_req(mce[2]), .bus_reset(brst[2]));

  err_line_agent #(.LINE_ROLE(ROLE_INIT)) u_init (
    .clk(clk), .rst_n(rst_n), .cfg_drv_en(cfg_a[3][5]), .cfg_int_src(cfg_a[3][4]),
    .cfg_init_src(cfg_a[3][3]), .cfg_any_src(cfg_a[3][2]), .cfg_rcv_en(cfg_a[3][1]),
    .cfg_mce_en(cfg_a[3][0]), .int_err(int_err[3]), .txn_err(txn_err[3]),
    .txn_mine(txn_mine[3]), .line_seen(line_seen), .others_seen(oth_seen[3]),
    .drive_en(drv[3]), .mce_req(mce[3]), .bus_reset(brst[3]));

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: pops the expected width of each agent-0 pull
  always @(negedge clk) begin
    if (rst_n) begin
      if (drv[0]) run0++;
      else if (run0 > 0) begin
        pulses0++;
        fall0 = cyc;
        if (exp_q.size() == 0) check(1'b0, "R2/R5/R6 unexpected pull on agent 0", run0, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check(run0 == e, "R1/R3/R4 pull width of agent 0", run0, e);
        end
        run0 = 0;
      end
      if (drv[1]) run1++;
      else if (run1 > 0) begin
        last_w1 = run1;
        fall1 = cyc;
        run1 = 0;
      end
      if (mce[0]) mce0_cnt++;
      if (brst[0]) brst0_cnt++;
      if (brst[3]) brst3_cnt++;
    end
  end

  task automatic do_reset(logic [5:0] c0, logic [5:0] c3);
    rst_n = 1'b0;
    cfg_a[0] = c0;
    cfg_a[1] = 6'b110111;
    cfg_a[2] = 6'b110111;
    cfg_a[3] = c3;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic req_int(logic [3:0] who);
    int_err = who;
    tick(1);
    int_err = '0;
  endtask

  task automatic req_txn(int k, logic mine);
    txn_err[k] = 1'b1;
    txn_mine[k] = mine;
    tick(1);
    txn_err[k] = 1'b0;
    txn_mine[k] = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1 watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int p, m, b;
    cfg_a[0] = '0; cfg_a[1] = '0; cfg_a[2] = '0; cfg_a[3] = '0;
    tick(2);
    // R11: reset state
    check(drv[0] == 1'b0, "R11 drive_en in reset", drv[0], 0);
    check(mce[0] == 1'b0, "R11 mce_req in reset", mce[0], 0);
    check(brst[3] == 1'b0, "R11 bus_reset in reset", brst[3], 0);

    do_reset(6'b110111, 6'b000010);

    // R1, R8, R9: single pull and single receiver events
    m = mce0_cnt; b = brst3_cnt;
    exp_q.push_back(3);
    req_int(4'b0001);
    tick(10);
    check(mce0_cnt - m == 1, "R8 one mce_req per episode", mce0_cnt - m, 1);
    check(brst3_cnt - b == 1, "R9 one bus_reset per episode", brst3_cnt - b, 1);
    check(brst0_cnt == 0, "R8 no bus_reset in fault role", brst0_cnt, 0);

    // R3: agent 1 starts, agent 0 one clock later
    exp_q.push_back(2);
    int_err = 4'b0010;
    tick(1);
    int_err = 4'b0001;
    tick(1);
    int_err = '0;
    tick(10);
    check(last_w1 == 3, "R3 first starter keeps full pull", last_w1, 3);
    check(fall0 == fall1, "R3 both release on the same clock", fall0, fall1);

    // R4: simultaneous start
    exp_q.push_back(3);
    req_int(4'b0011);
    tick(10);
    check(last_w1 == 3, "R4 simultaneous starter width", last_w1, 3);
    check(fall0 == fall1, "R4 simultaneous release", fall0, fall1);

    // R2: request while line active is dropped
    p = pulses0;
    int_err = 4'b0010;
    tick(1);
    int_err = '0;
    tick(1);
    check(line_seen == 1'b1, "R2 line active at request", line_seen, 1);
    req_int(4'b0001);
    tick(12);
    check(pulses0 == p, "R2 no pull from request on active line", pulses0 - p, 0);

    // R6: any-observed source
    p = pulses0;
    exp_q.push_back(3);
    req_txn(0, 1'b0);
    tick(10);
    check(pulses0 - p == 1, "R6 any-observed transaction error", pulses0 - p, 1);

    // R6: initiator-only, internal source off
    do_reset(6'b101011, 6'b000010);
    p = pulses0;
    req_txn(0, 1'b0);
    tick(8);
    check(pulses0 == p, "R6 not initiator", pulses0 - p, 0);
    req_int(4'b0001);
    tick(8);
    check(pulses0 == p, "R6 internal source disabled", pulses0 - p, 0);
    exp_q.push_back(3);
    req_txn(0, 1'b1);
    tick(10);
    check(pulses0 - p == 1, "R6 initiator-only pull", pulses0 - p, 1);

    // R5, R7: driver and receivers disabled
    do_reset(6'b010101, 6'b000000);
    p = pulses0; m = mce0_cnt; b = brst3_cnt;
    req_int(4'b0001);
    tick(8);
    check(pulses0 == p, "R5 driver disabled", pulses0 - p, 0);
    req_int(4'b0010);
    tick(10);
    check(last_w1 == 3, "R7 other agent pulled", last_w1, 3);
    check(mce0_cnt == m, "R7 receiver disabled mce_req", mce0_cnt - m, 0);
    check(brst3_cnt == b, "R7 receiver disabled bus_reset", brst3_cnt - b, 0);

    // R8: machine-check disabled
    do_reset(6'b110110, 6'b000010);
    m = mce0_cnt;
    req_int(4'b0010);
    tick(10);
    check(mce0_cnt == m, "R8 machine-check disabled", mce0_cnt - m, 0);

    // R10: late configuration changes ignored
    do_reset(6'b010111, 6'b000010);
    cfg_a[0] = 6'b110111;
    tick(2);
    p = pulses0;
    req_int(4'b0001);
    tick(10);
    check(pulses0 == p, "R10 late driver enable ignored", pulses0 - p, 0);
    do_reset(6'b110111, 6'b000010);
    cfg_a[0] = 6'b010111;
    tick(2);
    exp_q.push_back(3);
    req_int(4'b0001);
    tick(10);
    check(pulses0 - p == 1, "R10 late driver disable ignored", pulses0 - p, 1);

    check(exp_q.size() == 0, "R1 expected pulls not seen", exp_q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule